// File: doc/BRIEF.md
# Supply-Supervision Interrupt Register

This block is one 8-bit register on a 2-wire serial register bus that gathers the events of three supply monitors. The supplies are called C1, P2 and P1. Each monitor sends one-cycle pulses for three events: an under-voltage at -5%, an over-voltage, and a deep under-voltage spike at -10%. The over-voltage threshold is +8% for C1 and +5% for P1 and P2. The block keeps a sticky flag for each under and over event. It raises an interrupt line for every supply whose interrupt enable is set. It raises a shutdown request for the analog front end when a deep spike occurs on a supply whose shutdown enable is set.

Writes and reads at the register address reach different storage. A write sets hidden enable bits that can never be read back. A read returns the latched event flags and clears them in the same access. If an event arrives in the clearing cycle, its flag survives the read. The register has one reset, the analog-supply power-on reset, and it resets to 00h. The bus engine drives one-cycle read and write strobes together with the address and the write data.

Top module: `supmon_irq_reg`

## Requirements
- R1: After power-on reset, rd_data, irq and shutdown_req are all 0, and every enable is 0.
- R2: A write with address 23h loads the enables. Bit 7 is the C1 shutdown enable and bit 6 the C1 interrupt enable. Bits 3 and 2 are the same pair for P2, and bits 1 and 0 for P1. The new enables act from the cycle after the write.
- R3: A read with address 23h loads rd_data in the cycle after the strobe. Bit 7 is C1 under and bit 6 is C1 over. Bits 3 and 2 are P2 under and over. Bits 1 and 0 are P1 under and over. Bits 5:4 always read 0.
- R4: A read with address 23h clears every flag, so an immediately following read returns 0.
- R5: An event that arrives in the same cycle as a clearing read is absent from that read's data. Its flag stays set and is returned by the next read.
- R6: A flag sets on its event pulse and stays set until a read with address 23h clears it.
- R7: irq is the OR, over the three supplies, of (interrupt enable AND (under flag OR over flag)) for that supply.
- R8: A deep spike on a supply whose shutdown enable is 1 asserts shutdown_req in the next cycle. shutdown_req then stays high until power-on reset.
- R9: A deep spike on a supply whose shutdown enable is 0 leaves shutdown_req low. A deep spike never sets an under or over flag.
- R10: Strobes with any address other than 23h change neither the enables, nor the flags, nor rd_data.
- R11: The values written to bits 5:4 have no effect. No write changes the flags or rd_data.
- R12: Read data carries only flags, never the enable settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Analog-supply power-on reset, active low |
| bus_addr | input | 8 | Register address of the current access |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| uv_evt | input | 3 | -5% under-voltage pulses (index 0 P1, 1 P2, 2 C1) |
| ov_evt | input | 3 | Over-voltage pulses, indexed the same way |
| spike_evt | input | 3 | -10% deep spike pulses, indexed the same way |
| rd_data | output | 8 | Flags captured by the last read with address 23h |
| irq | output | 1 | Interrupt request |
| shutdown_req | output | 1 | Sticky shutdown request to the analog front end |

## Verification
The hardest case to reach is an event pulse that lands on the exact clock edge where a read clears the flags. The stimulus drives the read strobe and an event pulse for one supply in the same cycle. The bench expects the event to be missing from that read and present in the next one. Because enables cannot be read back, their effect is observed only through irq. The bench sweeps all 64 enable patterns against all 64 flag patterns. It then provokes shutdown with deep spikes, one supply at a time, with each supply's enable set and cleared.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

    localparam int NUM_SUP = 3;

    // lowest register bit of each supply's two-bit lane (P1, P2, C1)
    function automatic int lane_lsb(input int idx);
        case (idx)
            0:       lane_lsb = 0;
            1:       lane_lsb = 2;
            default: lane_lsb = 6;
        endcase
    endfunction

    typedef struct packed {
        logic under;
        logic over;
        logic irq_en;
        logic sd_en;
        logic sd;
    } lane_state_t;

endpackage

// File: rtl/supmon_decode.sv
module supmon_decode #(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h23
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              rd_hit,
    output logic              wr_hit
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

    logic sel;

    always_comb begin
        sel    = (addr == MATCH);
        rd_hit = rd & sel;
        wr_hit = wr & sel;
    end
endmodule

// File: rtl/supmon_lane.sv
module supmon_lane
    import supmon_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       wr_hit,
    input  logic [1:0] wbits,    // [1] shutdown enable, [0] interrupt enable
    input  logic       rd_hit,
    input  logic       uv,
    input  logic       ov,
    input  logic       spike,
    output logic [1:0] flags,    // [1] under, [0] over
    output logic       irq_o,
    output logic       sd_o
);
    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_hit) begin
            st_d.under = 1'b0;
            st_d.over  = 1'b0;
        end
        if (uv) st_d.under = 1'b1;
        if (ov) st_d.over  = 1'b1;
        if (spike && st_q.sd_en) st_d.sd = 1'b1;
        if (wr_hit) begin
            st_d.irq_en = wbits[0];
            st_d.sd_en  = wbits[1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        flags = {st_q.under, st_q.over};
        irq_o = st_q.irq_en & (st_q.under | st_q.over);
        sd_o  = st_q.sd;
    end

    assert_under_sets_R6: assert property (@(posedge clk) disable iff (!por_n)
        uv |=> st_q.under);
    assert_over_sets_R6: assert property (@(posedge clk) disable iff (!por_n)
        ov |=> st_q.over);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.under && !rd_hit) |=> st_q.under);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!por_n)
        (rd_hit && !uv && !ov) |=> (!st_q.under && !st_q.over));
    assert_sd_cause_R8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(st_q.sd) |-> $past(spike && st_q.sd_en));
    assert_sd_sticky_R8: assert property (@(posedge clk) disable iff (!por_n)
        st_q.sd |=> st_q.sd);
endmodule

// File: rtl/supmon_irq_reg.sv
module supmon_irq_reg
    import supmon_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'h23
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NUM_SUP-1:0] uv_evt,
    input  logic [NUM_SUP-1:0] ov_evt,
    input  logic [NUM_SUP-1:0] spike_evt,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              shutdown_req
);
    logic rd_hit, wr_hit;
    logic [DATA_W-1:0]  flag_word;
    logic [NUM_SUP-1:0] lane_irq, lane_sd;
    logic [1:0]         unused_wbits;

    typedef struct packed {
        logic [DATA_W-1:0] rdat;
    } top_state_t;

    top_state_t ts_d, ts_q;

    supmon_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .rd_hit (rd_hit),
        .wr_hit (wr_hit)
    );

    assign unused_wbits = bus_wdata[5:4];

    always_comb begin
        flag_word = '0;
        for (int k = 0; k < NUM_SUP; k++) begin
            flag_word[lane_lsb(k) +: 2] = lane_flags[k];
        end
    end

    logic [1:0] lane_flags [NUM_SUP];

    generate
        for (genvar g = 0; g < NUM_SUP; g++) begin : g_lane
            localparam int LSB = lane_lsb(g);
            supmon_lane u_lane (
                .clk    (clk),
                .por_n  (por_n),
                .wr_hit (wr_hit),
                .wbits  (bus_wdata[LSB +: 2]),
                .rd_hit (rd_hit),
                .uv     (uv_evt[g]),
                .ov     (ov_evt[g]),
                .spike  (spike_evt[g]),
                .flags  (lane_flags[g]),
                .irq_o  (lane_irq[g]),
                .sd_o   (lane_sd[g])
            );
        end
    endgenerate

    always_comb begin
        ts_d = ts_q;
        if (rd_hit) ts_d.rdat = flag_word;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) ts_q <= '0;
        else        ts_q <= ts_d;
    end

    always_comb begin
        rd_data      = ts_q.rdat;
        irq          = |lane_irq;
        shutdown_req = |lane_sd;
    end

    assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!por_n)
        rd_data[5:4] == 2'b00);
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!por_n)
        !rd_hit |=> $stable(rd_data));
    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!por_n)
        irq |-> (flag_word != '0));
    assert_sd_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
        shutdown_req |=> shutdown_req);
endmodule

// File: tb/tb_supmon_irq_reg.sv
module tb_supmon_irq_reg;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [2:0] uv_evt = '0, ov_evt = '0, spike_evt = '0;
    logic [7:0] rd_data;
    logic       irq, shutdown_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    supmon_irq_reg dut (
        .clk(clk), .por_n(por_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .uv_evt(uv_evt),
        .ov_evt(ov_evt), .spike_evt(spike_evt), .rd_data(rd_data),
        .irq(irq), .shutdown_req(shutdown_req)
    );

    function automatic int lsb_of(input int i);
        return (i == 0) ? 0 : (i == 1) ? 2 : 6;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        por_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic evt(input logic [2:0] u, input logic [2:0] o, input logic [2:0] s);
        uv_evt = u; ov_evt = o; spike_evt = s;
        @(negedge clk);
        uv_evt = '0; ov_evt = '0; spike_evt = '0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset values
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 shutdown", {7'd0, shutdown_req}, 8'h00);

        // R2 R3 R7 R11 R12: sweep enables x flags
        for (int e = 0; e < 64; e++) begin
            logic [7:0] wb;
            wb = '0;
            for (int i = 0; i < 3; i++) wb[lsb_of(i) +: 2] = e[2*i +: 2];
            wb[5:4] = e[1:0] ^ 2'b10;
            wr(8'h23, wb);
            for (int f = 0; f < 64; f++) begin
                logic [2:0] u, o;
                logic [7:0] eb;
                logic ei;
                eb = '0; ei = 1'b0;
                for (int i = 0; i < 3; i++) begin
                    u[i] = f[2*i+1];
                    o[i] = f[2*i];
                    eb[lsb_of(i) +: 2] = f[2*i +: 2];
                    ei |= e[2*i] & (f[2*i] | f[2*i+1]);
                end
                evt(u, o, 3'b000);
                chk("R7 irq", {7'd0, irq}, {7'd0, ei});
                rd(8'h23);
                chk("R3 R12 rd_data", rd_data, eb);
                chk("R4 irq after clear", {7'd0, irq}, 8'h00);
            end
        end
        chk("R9 no shutdown without spikes", {7'd0, shutdown_req}, 8'h00);

        // R4 double read
        evt(3'b111, 3'b111, 3'b000);
        rd(8'h23);
        chk("R4 first read", rd_data, 8'hCF);
        rd(8'h23);
        chk("R4 second read", rd_data, 8'h00);

        // R5 event coincident with read
        uv_evt = 3'b010;
        rd(8'h23);
        uv_evt = '0;
        chk("R5 coincident excluded", rd_data, 8'h00);
        rd(8'h23);
        chk("R5 survives to next read", rd_data, 8'h08);

        // R6 sticky across idle cycles
        evt(3'b000, 3'b100, 3'b000);
        repeat (10) @(negedge clk);
        rd(8'h23);
        chk("R6 sticky", rd_data, 8'h40);

        // R10 other addresses
        wr(8'h23, 8'h01);              // P1 irq enable
        evt(3'b000, 3'b001, 3'b000);
        rd(8'h22);
        chk("R10 rd_data unchanged", rd_data, 8'h40);
        chk("R10 flag not cleared", {7'd0, irq}, 8'h01);
        wr(8'h24, 8'h00);
        chk("R10 enable kept", {7'd0, irq}, 8'h01);
        wr(8'h23, 8'h30);              // only unused bits set
        chk("R11 enables cleared, bits 5:4 ignored", {7'd0, irq}, 8'h00);
        chk("R11 write leaves rd_data", rd_data, 8'h40);
        rd(8'h23);
        chk("R11 flag kept across write", rd_data, 8'h01);

        // R8 R9 shutdown per supply
        for (int i = 0; i < 3; i++) begin
            for (int en = 0; en < 2; en++) begin
                logic [7:0] wb;
                do_reset();
                wb = '0;
                wb[lsb_of(i) + 1] = en[0];
                wr(8'h23, wb);
                wr(8'h24, 8'hFF);      // wrong address: no enable change
                evt(3'b000, 3'b000, 3'b111 & ~(3'b001 << i));
                chk("R9 other supplies no shutdown", {7'd0, shutdown_req}, 8'h00);
                evt(3'b000, 3'b000, 3'b001 << i);
                chk(en ? "R8 shutdown asserted" : "R9 shutdown stays low",
                    {7'd0, shutdown_req}, {7'd0, en[0]});
                wr(8'h23, 8'h00);
                rd(8'h23);
                chk("R9 spike sets no flag", rd_data, 8'h00);
                repeat (3) @(negedge clk);
                chk("R8 shutdown sticky", {7'd0, shutdown_req}, {7'd0, en[0]});
            end
        end
        do_reset();
        chk("R8 cleared by reset", {7'd0, shutdown_req}, 8'h00);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule